// File: doc/BRIEF.md
# Thermal Throttle Time Accumulator

This block watches an active-low thermal throttle pin and adds up, across all of its low periods, how long it has been held low. A free-running prescaler advances only while the throttle is active. Each time it wraps, it adds one unit to a saturating 8-bit time counter. At the intended rate one unit is about 22.76 ms, so 8 units are about 182 ms and 128 units are about 2.9 s. Software reads the counter over a simple register port, and the read clears it. This lets software sample the accumulated throttle time at fixed intervals, or time how long the counter takes to pass a programmed limit.

When the accumulated time passes the programmed limit, the block latches an alert request, unless a mask bit suppresses it. A limit of zero makes the first throttle assertion raise the alert. When a boost bit is set and the fans were already running at the moment the throttle asserted, the block also drives a full-duty override to the fan controller for as long as the throttle remains active.

The register port is a plain control port with no back-pressure. A write takes effect at the clock edge on which `reg_we_i` is high. Read data is combinational from `reg_addr_i`. A read side effect, a clear, happens at the edge on which `reg_re_i` is high.

Top module: `thermal_timer_mon`

## Requirements
- R1: After reset, `alert_o` and `fan_boost_o` are 0, and the control, mask, limit, timer and status registers all read 0.
- R2: The throttle is active only when control bits [1:0] equal 2'b11 (pin used as throttle input) and control bit 2 (timer enable) is 1. Otherwise a low pin leaves the timer count unchanged and raises neither boost nor alert.
- R3: While the throttle is active, the timer (address 3) gains one count per TICK_CYCLES active clock cycles. The partial prescaler count is kept between separate low periods.
- R4: The timer saturates at 255 and never wraps.
- R5: A read of address 3 returns the count and clears it. If a prescaler tick falls in the same cycle as the read, the count after the read is 1.
- R6: With the limit (address 2) equal to 0 and the mask clear, the start of a throttle assertion sets the alert.
- R7: With a nonzero limit, the alert is set when the count becomes strictly greater than the limit, and not when it only equals the limit.
- R8: When mask bit 0 (address 1) is 1, no alert is set.
- R9: The alert is status bit 0 (address 4). It stays set after the throttle releases, until address 4 is read. That read returns 1 and clears the alert.
- R10: With control bit 3 (boost enable) set and `fan_running_i` high in the cycle the throttle becomes active, `fan_boost_o` is 1 while the throttle stays active and returns to 0 when it releases.
- R11: If `fan_running_i` is low when the throttle becomes active, `fan_boost_o` stays 0 for that assertion, even if the fans start later. With the boost bit clear, `fan_boost_o` stays 0.
- R12: The pin passes through a two-flop synchroniser. A pin driven low before clock edge 1 shows as `fan_boost_o` high after edge 3 and not after edge 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| therm_ni | input | 1 | Asynchronous active-low throttle pin |
| fan_running_i | input | 1 | Fans currently spinning |
| reg_addr_i | input | 3 | Register select: 0 control, 1 mask, 2 limit, 3 timer, 4 status |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears timer or status) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| fan_boost_o | output | 1 | Force all fans to full duty |
| alert_o | output | 1 | Latched alert request |

## Verification
Two functions can fall in the same cycle: the read-and-clear of the timer and a prescaler tick that increments it. The bench holds the pin low from a known edge, counts the edges, and places the timer read exactly on the cycle of the second tick. It then checks that the read returns the old count of 1, and that a later read also returns 1, because the tick that arrived during the clear is kept. A design where the clear wins reports 0 on the later read.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_LIMIT  = 3'd2,
    SEL_TIMER  = 3'd3,
    SEL_STATUS = 3'd4
  } reg_sel_e;

  localparam logic [1:0] PIN_THROTTLE = 2'b11;

  typedef struct packed {
    logic [3:0] unused;
    logic       boost_en;
    logic       tmr_en;
    logic [1:0] pin_mode;
  } ctrl_t;
endpackage

// File: rtl/ttm_sync.sv
module ttm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ttm_prescale.sv
module ttm_prescale #(
  parameter int TICK_CYCLES = 1138000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  a_r3_prescale_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/ttm_accum.sv
module ttm_accum #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= tick_i ? W'(1) : '0;
    else if (tick_i && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAXV && !clr_i) |=> cnt_q == MAXV);
  a_r5_clear_keeps_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && tick_i) |=> cnt_q == W'(1));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> cnt_q == '0);
endmodule

// File: rtl/thermal_timer_mon.sv
module thermal_timer_mon
  import ttm_pkg::*;
#(
  parameter int TICK_CYCLES = 1138000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             therm_ni,
  input  logic             fan_running_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             fan_boost_o,
  output logic             alert_o
);
  ctrl_t            ctrl_q;
  logic             mask_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] count;
  logic             pin_sync_n;
  logic             active, active_q, act_rise;
  logic             tick, tmr_clr, st_clr;
  logic             exceed, exceed_q, alert_evt;
  logic             boost_q, alert_q;

  ttm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(therm_ni), .sync_o(pin_sync_n));

  assign active = !pin_sync_n && (ctrl_q.pin_mode == PIN_THROTTLE) && ctrl_q.tmr_en;

  ttm_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(active), .tick_o(tick));

  assign tmr_clr = reg_re_i && (reg_addr_i == SEL_TIMER);
  assign st_clr  = reg_re_i && (reg_addr_i == SEL_STATUS);

  ttm_accum #(.W(CNT_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .clr_i(tmr_clr), .count_o(count));

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      mask_q  <= 1'b0;
      limit_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        SEL_CTRL:  ctrl_q  <= ctrl_t'({4'b0, reg_wdata_i[3:0]});
        SEL_MASK:  mask_q  <= reg_wdata_i[0];
        SEL_LIMIT: limit_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  assign act_rise  = active && !active_q;
  assign exceed    = (limit_q != '0) && (count > limit_q);
  assign alert_evt = ((limit_q == '0) && act_rise) || (exceed && !exceed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      exceed_q <= 1'b0;
      boost_q  <= 1'b0;
      alert_q  <= 1'b0;
    end else begin
      active_q <= active;
      exceed_q <= exceed;
      if (!active || !ctrl_q.boost_en)  boost_q <= 1'b0;
      else if (act_rise && fan_running_i) boost_q <= 1'b1;
      if (alert_evt && !mask_q) alert_q <= 1'b1;
      else if (st_clr)          alert_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_i)
      SEL_CTRL:   reg_rdata_o = ctrl_q;
      SEL_MASK:   reg_rdata_o = {7'b0, mask_q};
      SEL_LIMIT:  reg_rdata_o = limit_q;
      SEL_TIMER:  reg_rdata_o = count;
      SEL_STATUS: reg_rdata_o = {7'b0, alert_q};
      default:    reg_rdata_o = '0;
    endcase
  end

  assign fan_boost_o = boost_q;
  assign alert_o     = alert_q;

  a_r10_boost_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !fan_boost_o);
  a_r11_boost_needs_fan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fan_boost_o) |-> $past(fan_running_i));
  a_r8_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !alert_o) |=> !alert_o);
  a_r2_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !tmr_clr) |=> $stable(count));
  a_r9_alert_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_o && !st_clr) |=> alert_o);
endmodule

// File: tb/test_thermal_timer_mon.sv
`timescale 1ns/1ps
module test_thermal_timer_mon;
  logic clk = 0, rst_n = 0, therm_n = 1, fan_run = 0;
  logic [2:0] addr = 0;
  logic we = 0, re = 0;
  logic [7:0] wdata = 0, rdata;
  logic boost, alert;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  thermal_timer_mon #(.TICK_CYCLES(8)) i_thermal_timer_mon (
    .clk_i(clk), .rst_ni(rst_n), .therm_ni(therm_n), .fan_running_i(fan_run),
    .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .fan_boost_o(boost), .alert_o(alert));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; therm_n = 1; fan_run = 0; we = 0; re = 0;
    repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1; @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; re = 1; #1 d = rdata; @(negedge clk); re = 0;
  endtask

  task automatic hold_low(input int n);
    therm_n = 0; repeat (n) @(negedge clk); therm_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check("R1 alert", alert, 0); check("R1 boost", boost, 0);
    rd(0, d); check("R1 ctrl", d, 0);
    rd(2, d); check("R1 limit", d, 0);
    rd(3, d); check("R1 timer", d, 0);
    rd(4, d); check("R1 status", d, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    do_reset(); fan_run = 1;
    wr(0, 8'h0B);                    // throttle pin, boost, timer off
    therm_n = 0; repeat (20) @(negedge clk);
    check("R2 no boost when off", boost, 0);
    therm_n = 1; repeat (4) @(negedge clk);
    rd(3, d); check("R2 no count when off", d, 0);
    check("R2 no alert when off", alert, 0);
    wr(0, 8'h0D);                    // pin mode 01, enable, boost
    hold_low(40);
    rd(3, d); check("R2 no count tach mode", d, 0);
  endtask

  task automatic t_accum();
    logic [7:0] d;
    do_reset(); wr(0, 8'h07);
    hold_low(24);
    rd(3, d); check("R3 count 3", d, 3);
    rd(3, d); check("R5 cleared", d, 0);
    hold_low(4); hold_low(4);
    rd(3, d); check("R3 residual kept", d, 1);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    do_reset(); wr(0, 8'h07);
    therm_n = 0;                     // low before edge 1; ticks at edges 10,18
    repeat (17) @(negedge clk);
    rd(3, d);                        // read strobe spans edge 18
    therm_n = 1;
    check("R5 read value at tick", d, 1);
    repeat (6) @(negedge clk);
    rd(3, d); check("R5 tick kept over clear", d, 1);
  endtask

  task automatic t_saturate();
    logic [7:0] d;
    do_reset(); wr(0, 8'h07);
    hold_low(2400);
    rd(3, d); check("R4 saturate", d, 255);
  endtask

  task automatic t_limit0();
    logic [7:0] d;
    do_reset(); wr(0, 8'h07);
    therm_n = 0; repeat (4) @(negedge clk);
    check("R6 alert on first assertion", alert, 1);
    therm_n = 1; repeat (10) @(negedge clk);
    check("R9 alert latched", alert, 1);
    rd(4, d); check("R9 status read", d, 1);
    check("R9 cleared by read", alert, 0);
  endtask

  task automatic t_limitn();
    do_reset(); wr(0, 8'h07); wr(2, 8'd2);
    hold_low(16);
    check("R7 no alert at equal", alert, 0);
    hold_low(8);
    check("R7 alert above limit", alert, 1);
  endtask

  task automatic t_mask();
    do_reset(); wr(0, 8'h07); wr(1, 8'h01);
    hold_low(8);
    check("R8 masked", alert, 0);
  endtask

  task automatic t_boost();
    do_reset(); wr(0, 8'h0F); fan_run = 1;
    therm_n = 0;                     // before edge 1
    repeat (2) @(negedge clk);
    check("R12 no boost after edge 2", boost, 0);
    @(negedge clk);
    check("R12 boost after edge 3", boost, 1);
    repeat (20) @(negedge clk);
    check("R10 boost held", boost, 1);
    therm_n = 1; repeat (4) @(negedge clk);
    check("R10 boost released", boost, 0);
  endtask

  task automatic t_noboost();
    do_reset(); wr(0, 8'h0F); fan_run = 0;
    therm_n = 0; repeat (5) @(negedge clk);
    fan_run = 1; repeat (10) @(negedge clk);
    check("R11 no boost fans idle", boost, 0);
    therm_n = 1; repeat (4) @(negedge clk);
    wr(0, 8'h07);
    therm_n = 0; repeat (10) @(negedge clk);
    check("R11 no boost bit clear", boost, 0);
    therm_n = 1; repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset(); t_disabled(); t_accum(); t_collide(); t_saturate();
    t_limit0(); t_limitn(); t_mask(); t_boost(); t_noboost();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule